// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block divides one fast source clock into three output banks (A, B, C) and a feedback output. Each output has its own ratio select. Every ratio is even, so each output is a 50% duty square wave. All logic runs on the source clock `clk`, and the divided outputs are registered levels.

An optional pre-divide stage halves the rate at which the dividers advance. A bypass control swaps the always-on source for a reference strobe `ref_tick`, which is sampled on `clk`. An active-low master reset clears every divider and drops the output-enable `out_en`. While `out_en` is low, every data output is held at 0, which models the tri-state condition. Bank C has four outputs, and two of them can be inverted against the other two.

Top module: `clkdiv_banks`

## Requirements
- R1: Bank A: `sel_a` values 0, 1, 2 and 3 give periods of 4, 6, 8 and 12 advance ticks. The output is high for the first half of each period.
- R2: Bank B: `sel_b` values 0, 1, 2 and 3 give periods of 4, 6, 8 and 10 advance ticks, with a 50% duty cycle.
- R3: Bank C: `sel_c` values 0, 1, 2 and 3 give periods of 2, 4, 6 and 8 advance ticks, with a 50% duty cycle.
- R4: Feedback: `sel_fb` values 0 to 7 give periods of 4, 6, 8, 10, 8, 12, 16 and 20 advance ticks, with a 50% duty cycle.
- R5: With `full_rate`=1, every source tick advances the dividers. With `full_rate`=0, only alternate source ticks do, starting with the first tick after reset.
- R6: With `pll_on`=1, every `clk` cycle is a source tick. With `pll_on`=0, only cycles with `ref_tick`=1 are source ticks, and the outputs hold their values otherwise.
- R7: On the edge after `mr_n` is sampled low, `out_en` is 0, all data outputs are 0 and all divider state is cleared.
- R8: With `inv`=1, `qc[1]` and `qc[2]` are the complement of `qc[0]` and `qc[3]`. With `inv`=0, all four bits of `qc` are equal.
- R9: On the first advance tick after reset is released, every output goes high on the same edge, so the banks stay phase-aligned.
- R10: A change of ratio select takes effect only when the current output period completes. The running period keeps its old length.
- R11: A synchronous active-high `rst` has the same effect as `mr_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_n | input | 1 | Active-low master reset and output disable |
| pll_on | input | 1 | 1: every cycle ticks; 0: bypass to `ref_tick` |
| ref_tick | input | 1 | Reference strobe used in bypass |
| full_rate | input | 1 | 1: no pre-divide; 0: halve the tick rate |
| inv | input | 1 | Invert `qc[1]` and `qc[2]` |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 3 | Feedback ratio select |
| out_en | output | 1 | Output enable (0 = tri-stated) |
| qa | output | 1 | Bank A output |
| qb | output | 1 | Bank B output |
| qc | output | 4 | Bank C outputs |
| qfb | output | 1 | Feedback output |

## Verification
The bench checks the places where the ratio tables break a simple pattern. Bank A's last entry is 12, not 10, and the feedback table repeats 8. A decoder that assumed linear steps would give the wrong period there.

A ratio select is changed in the middle of a period. A design that reloads at once would cut the period short and emit a runt pulse.

The pre-divide and bypass modes are run with an irregular reference strobe. A design that ticks on every cycle, or that starts the halving on the wrong phase, would drift away from the expected waveform.

The first cycle after reset release is checked for all outputs rising together. The master reset is also pulled low in mid-run, which would expose a divider that keeps counting or leaves outputs driven while disabled.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CNT_W   = 5;
    localparam int SEL_W   = 3;
    localparam int N_LANES = 4;

    typedef enum logic [1:0] {
        LANE_A  = 2'd0,
        LANE_B  = 2'd1,
        LANE_C  = 2'd2,
        LANE_FB = 2'd3
    } lane_kind_e;

    typedef logic [CNT_W-1:0] ratio_t;

    // Ratio in advance ticks for a lane kind and its select code.
    function automatic ratio_t ratio_of(lane_kind_e kind, logic [SEL_W-1:0] sel);
        ratio_t step;
        step = ratio_t'(sel[1:0]);
        case (kind)
            LANE_A:  ratio_of = (sel[1:0] == 2'd3) ? ratio_t'(12) : ratio_t'(4) + (step << 1);
            LANE_B:  ratio_of = ratio_t'(4) + (step << 1);
            LANE_C:  ratio_of = ratio_t'(2) + (step << 1);
            default: ratio_of = sel[2] ? ratio_t'(8) + (step << 2) : ratio_t'(4) + (step << 1);
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_tickgen.sv
module clkdiv_tickgen (
    input  logic clk,
    input  logic clr,
    input  logic pll_on,
    input  logic ref_tick,
    input  logic full_rate,
    output logic tick
);
    logic src;
    logic phase;

    assign src  = pll_on | ref_tick;
    assign tick = src & (full_rate | phase);

    // Phase bit of the halving stage; starts so the first source tick passes.
    always_ff @(posedge clk) begin
        if (clr) begin
            phase <= 1'b1;
        end else if (src) begin
            phase <= ~phase;
        end
    end
endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane
    import clkdiv_pkg::*;
(
    input  logic   clk,
    input  logic   clr,
    input  logic   tick,
    input  ratio_t ratio,
    output logic   q
);
    logic   armed;
    ratio_t pos;
    ratio_t len;
    ratio_t pos_nx;
    logic   wrap;

    assign pos_nx = pos + ratio_t'(1);
    assign wrap   = !armed || (pos == len - ratio_t'(1));

    always_ff @(posedge clk) begin
        if (clr) begin
            armed <= 1'b0;
            pos   <= '0;
            len   <= '0;
            q     <= 1'b0;
        end else if (tick) begin
            if (wrap) begin
                armed <= 1'b1;
                pos   <= '0;
                len   <= ratio;
                q     <= 1'b1;
            end else begin
                pos   <= pos_nx;
                q     <= pos_nx < (len >> 1);
            end
        end
    end
endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mr_n,
    input  logic       pll_on,
    input  logic       ref_tick,
    input  logic       full_rate,
    input  logic       inv,
    input  logic [1:0] sel_a,
    input  logic [1:0] sel_b,
    input  logic [1:0] sel_c,
    input  logic [2:0] sel_fb,
    output logic       out_en,
    output logic       qa,
    output logic       qb,
    output logic [3:0] qc,
    output logic       qfb
);
    localparam int QC_W = 4;

    logic                          clr;
    logic                          tick;
    logic [N_LANES-1:0]            lane_q;
    logic [N_LANES-1:0][SEL_W-1:0] sel_vec;

    assign clr = rst | ~mr_n;

    assign sel_vec[LANE_A]  = {1'b0, sel_a};
    assign sel_vec[LANE_B]  = {1'b0, sel_b};
    assign sel_vec[LANE_C]  = {1'b0, sel_c};
    assign sel_vec[LANE_FB] = sel_fb;

    always_ff @(posedge clk) begin
        if (clr) begin
            out_en <= 1'b0;
        end else begin
            out_en <= 1'b1;
        end
    end

    clkdiv_tickgen u_tick (
        .clk       (clk),
        .clr       (clr),
        .pll_on    (pll_on),
        .ref_tick  (ref_tick),
        .full_rate (full_rate),
        .tick      (tick)
    );

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        clkdiv_lane u_lane (
            .clk   (clk),
            .clr   (clr),
            .tick  (tick),
            .ratio (ratio_of(lane_kind_e'(k), sel_vec[k])),
            .q     (lane_q[k])
        );
    end

    assign qa  = out_en & lane_q[LANE_A];
    assign qb  = out_en & lane_q[LANE_B];
    assign qfb = out_en & lane_q[LANE_FB];

    for (genvar i = 0; i < QC_W; i++) begin : g_qc
        localparam bit FLIP = (i == 1) || (i == 2);
        assign qc[i] = out_en & (lane_q[LANE_C] ^ (inv & FLIP));
    end
endmodule

// File: rtl/clkdiv_banks_chk.sv
module clkdiv_banks_chk (
    input logic       clk,
    input logic       rst,
    input logic       mr_n,
    input logic       pll_on,
    input logic       ref_tick,
    input logic       full_rate,
    input logic       inv,
    input logic       out_en,
    input logic       qa,
    input logic       qb,
    input logic [3:0] qc,
    input logic       qfb
);
    AST_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        !mr_n |=> (!out_en && !qa && !qb && qc == 4'b0 && !qfb)); // R7

    AST_RST_OFF: assert property (@(posedge clk)
        rst |=> (!out_en && qc == 4'b0)); // R11

    AST_INV_PAIR: assert property (@(posedge clk) disable iff (rst)
        (out_en && inv) |-> (qc[1] == !qc[0] && qc[2] == !qc[3] && qc[0] == qc[3])); // R8

    AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_en && mr_n && !pll_on && !ref_tick)
            |=> ($stable(qa) && $stable(qb) && $stable(qc[0]) && $stable(qfb))); // R6

    AST_FIRST_RISE: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_en) && $past(pll_on) && $past(full_rate))
            |-> (qa && qb && qc[0] && qfb)); // R9
endmodule

bind clkdiv_banks clkdiv_banks_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mr_n      (mr_n),
    .pll_on    (pll_on),
    .ref_tick  (ref_tick),
    .full_rate (full_rate),
    .inv       (inv),
    .out_en    (out_en),
    .qa        (qa),
    .qb        (qb),
    .qc        (qc),
    .qfb       (qfb)
);

// File: tb/test_clkdiv_banks.sv
module test_clkdiv_banks;
    logic       clk = 1'b0;
    logic       rst, mr_n, pll_on, ref_tick, full_rate, inv;
    logic [1:0] sel_a, sel_b, sel_c;
    logic [2:0] sel_fb;
    logic       out_en, qa, qb, qfb;
    logic [3:0] qc;

    int checks = 0;
    int errors = 0;

    // Bench model state
    bit m_oe, m_ph;
    bit m_arm [4];
    int m_pos [4];
    int m_len [4];

    always #2 clk = ~clk;

    clkdiv_banks i_clkdiv_banks (
        .clk(clk), .rst(rst), .mr_n(mr_n), .pll_on(pll_on), .ref_tick(ref_tick),
        .full_rate(full_rate), .inv(inv), .sel_a(sel_a), .sel_b(sel_b),
        .sel_c(sel_c), .sel_fb(sel_fb), .out_en(out_en), .qa(qa), .qb(qb),
        .qc(qc), .qfb(qfb)
    );

    function automatic int want_ratio(int lane);
        case (lane)
            0: case (sel_a) 2'd0: return 4; 2'd1: return 6; 2'd2: return 8; default: return 12; endcase
            1: case (sel_b) 2'd0: return 4; 2'd1: return 6; 2'd2: return 8; default: return 10; endcase
            2: case (sel_c) 2'd0: return 2; 2'd1: return 4; 2'd2: return 6; default: return 8; endcase
            default:
                case (sel_fb)
                    3'd0: return 4;  3'd1: return 6;  3'd2: return 8;  3'd3: return 10;
                    3'd4: return 8;  3'd5: return 12; 3'd6: return 16; default: return 20;
                endcase
        endcase
    endfunction

    function automatic bit lane_exp(int lane);
        return m_oe && m_arm[lane] && (m_pos[lane] < m_len[lane] / 2);
    endfunction

    function automatic logic [7:0] exp_vec();
        bit c;
        c = lane_exp(2);
        return {m_oe, lane_exp(0), lane_exp(1),
                c, c ^ (m_oe & inv), c ^ (m_oe & inv), c, lane_exp(3)};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic step(string tag);
        bit src, tk;
        @(posedge clk);
        if (rst || !mr_n) begin
            m_oe = 0; m_ph = 1;
            for (int l = 0; l < 4; l++) begin m_arm[l] = 0; m_pos[l] = 0; m_len[l] = 0; end
        end else begin
            m_oe = 1;
            src = pll_on || ref_tick;
            tk  = src && (full_rate || m_ph);
            if (src) m_ph = !m_ph;
            if (tk) begin
                for (int l = 0; l < 4; l++) begin
                    if (!m_arm[l] || m_pos[l] == m_len[l] - 1) begin
                        m_arm[l] = 1; m_pos[l] = 0; m_len[l] = want_ratio(l);
                    end else begin
                        m_pos[l]++;
                    end
                end
            end
        end
        @(negedge clk);
        chk(tag, {out_en, qa, qb, qc, qfb}, exp_vec());
    endtask

    task automatic restart();
        mr_n = 0;
        step("R7");
        mr_n = 1;
    endtask

    task automatic t_reset();
        rst = 1; mr_n = 1; pll_on = 1; ref_tick = 0; full_rate = 1; inv = 0;
        sel_a = 0; sel_b = 0; sel_c = 0; sel_fb = 0;
        step("R11");
        step("R11");
        chk("R11", {out_en, qa, qb, qc, qfb}, 8'h00);
        rst = 0;
    endtask

    task automatic t_align();
        sel_a = 2'd3; sel_b = 2'd2; sel_c = 2'd1; sel_fb = 3'd7;
        restart();
        step("R9");
        chk("R9", {out_en, qa, qb, qc[0], qfb}, 5'h1F);
        for (int i = 0; i < 40; i++) step("R9");
    endtask

    task automatic t_tables();
        for (int s = 0; s < 4; s++) begin
            sel_a = 2'(s); sel_b = 2'(3 - s); sel_c = 2'(s); sel_fb = 3'(s);
            restart();
            for (int i = 0; i < 30; i++) step(s == 3 ? "R1" : "R2");
        end
        for (int s = 4; s < 8; s++) begin
            sel_fb = 3'(s); sel_c = 2'(s - 4);
            restart();
            for (int i = 0; i < 42; i++) step(s == 4 ? "R4" : "R3");
        end
    endtask

    task automatic t_prediv();
        full_rate = 0; sel_a = 0; sel_c = 0; sel_fb = 3'd4;
        restart();
        for (int i = 0; i < 40; i++) step("R5");
        full_rate = 1;
    endtask

    task automatic t_bypass();
        pll_on = 0; sel_c = 2'd1;
        restart();
        for (int i = 0; i < 60; i++) begin
            ref_tick = (i % 3 == 0) || (i % 7 == 2);
            step("R6");
        end
        full_rate = 0;
        for (int i = 0; i < 40; i++) begin
            ref_tick = (i % 2 == 1);
            step("R6");
        end
        ref_tick = 0; pll_on = 1; full_rate = 1;
    endtask

    task automatic t_midreset();
        sel_a = 2'd2; sel_fb = 3'd5;
        restart();
        for (int i = 0; i < 7; i++) step("R7");
        mr_n = 0;
        step("R7");
        chk("R7", {out_en, qa, qb, qc, qfb}, 8'h00);
        step("R7");
        mr_n = 1;
        for (int i = 0; i < 10; i++) step("R7");
    endtask

    task automatic t_invert();
        inv = 1; sel_c = 2'd2;
        restart();
        for (int i = 0; i < 20; i++) step("R8");
        chk("R8", {2'b00, qc[1] ^ qc[0], qc[2] ^ qc[3]}, 4'b0011);
        inv = 0;
        for (int i = 0; i < 8; i++) step("R8");
    endtask

    task automatic t_change();
        sel_a = 2'd3; sel_b = 2'd0; sel_c = 2'd3; sel_fb = 3'd7;
        restart();
        for (int i = 0; i < 3; i++) step("R10");
        sel_a = 2'd0; sel_b = 2'd3; sel_c = 2'd0; sel_fb = 3'd0;
        for (int i = 0; i < 30; i++) step("R10");
        sel_fb = 3'd6;
        for (int i = 0; i < 2; i++) step("R10");
        sel_fb = 3'd1;
        for (int i = 0; i < 30; i++) step("R10");
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_align();
        t_tables();
        t_prediv();
        t_bypass();
        t_midreset();
        t_invert();
        t_change();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule